// File: doc/BRIEF.md
# Rotating-Priority Channel Arbiter

This block picks one hardware transfer channel out of a wide request vector (256 channels by default) and hands it to a downstream arbiter. The channel number and that channel's descriptor pointer travel together on a valid/ready bundle. The pointer comes from a per-channel table that is written through a synchronous port. Fairness comes from a rotating order. Once a channel wins, it drops to the bottom of the order, and the channel just above it moves to the top, wrapping past the highest number back to zero.

A grant covers a whole chain of descriptors. While the chain runs, the block ignores the request vector. It offers each updated descriptor pointer on the same bundle, and the channel number stays unchanged. A chain-done strobe returns the block to idle. Arbitration resumes from the next cycle.

Top module: `chain_rr_arbiter`

## Requirements
- R1: After reset, out_valid_o is low and the priority search starts at channel 0, as if channel NUM_CH-1 had been the last one granted.
- R2: When idle, the block grants the first requesting channel in the current order. With the reset order and channels 5 and 6 both requesting, channel 5 wins. The offer appears one clock after the requests are sampled.
- R3: The granted channel becomes the lowest priority, and the next search starts at the granted channel plus one, modulo NUM_CH. In the 5 and 6 case, the next grant goes to 6. After channel 255 is granted, channel 0 is next in line. A lone requester is granted again.
- R4: The offered pointer is the table entry of the granted channel. A table write takes effect at the clock edge. A write to the same index in the grant cycle is not seen by that grant, which carries the old entry.
- R5: While out_valid_o is high and out_ready_i is low, out_valid_o, out_ch_o and out_ptr_o hold their values. A cycle with both high ends the offer, and out_valid_o is low in the next cycle.
- R6: During a chain with no offer pending, chain_upd_i raises out_valid_o one cycle later. out_ptr_o then equals chain_ptr_i and out_ch_o is unchanged.
- R7: From a grant until chain_done_i is accepted, the request vector has no effect. The next grant can occur at the first clock edge after the one that accepts chain_done_i.
- R8: While an offer is pending, chain_upd_i and chain_done_i are ignored. When no offer is pending and both strobes arrive together, chain_done_i wins and the update is dropped.
- R9: With the block idle and no request present, out_valid_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | NUM_CH | One request line per channel |
| tbl_we_i | input | 1 | Pointer table write enable |
| tbl_idx_i | input | CH_W | Pointer table write index |
| tbl_ptr_i | input | PTR_W | Pointer table write data |
| chain_upd_i | input | 1 | Strobe: next descriptor pointer of the running chain |
| chain_ptr_i | input | PTR_W | Updated descriptor pointer |
| chain_done_i | input | 1 | Strobe: running chain has finished |
| out_ready_i | input | 1 | Downstream accepts the offer |
| out_valid_o | output | 1 | Offer present |
| out_ch_o | output | CH_W | Granted channel |
| out_ptr_o | output | PTR_W | Descriptor pointer offered |

## Verification
Two channels that request together and keep requesting show whether the winner alternates or the lower number always wins. Requests at 200, 255 and 3 show whether the search wraps correctly past the top of the range. A lone requester shows that a full turn of the order comes back to the same channel. Requests held through a chain, updates and done strobes sent while an offer is pending, and a table write that lands in the grant cycle expose an arbiter that re-arbitrates too early, one that drops the pending offer, and a table read from the wrong side of the write.

// File: rtl/arb_pkg.sv
// Package: shared types for the rotating-priority channel arbiter.
// Assumes nothing beyond standard SystemVerilog.
package arb_pkg;
    // Arbiter phase: waiting for a request, or owning a chain.
    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_CHAIN = 1'b1
    } arb_phase_e;
endpackage

// File: rtl/rr_pick.sv
// rr_pick: combinational rotating search. Returns the first set bit
// of req at or after position last+1, wrapping modulo N.
// Assumes N >= 2 and W wide enough to hold N-1.
module rr_pick #(
    parameter int N = 256,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] last,
    output logic         found,
    output logic [W-1:0] sel
);
    // Scan offsets 1..N from the last grant and keep the first hit.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = 1; i <= N; i++) begin
            int unsigned idx;
            idx = (int'(last) + i) % N;
            if (!found && req[idx]) begin
                found = 1'b1;
                sel   = W'(idx);
            end
        end
    end
endmodule

// File: rtl/ptr_table.sv
// ptr_table: per-channel descriptor pointer store. Synchronous write,
// combinational read. A read in the write cycle returns the old entry.
// Assumes the reset clears every entry to zero.
module ptr_table #(
    parameter int N  = 256,
    parameter int W  = $clog2(N),
    parameter int PW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [W-1:0]  widx,
    input  logic [PW-1:0] wdata,
    input  logic [W-1:0]  ridx,
    output logic [PW-1:0] rdata
);
    logic [PW-1:0] mem_q [N];

    // Clear on reset, otherwise store the written entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[widx] <= wdata;
        end
    end

    // Read port seen by the grant logic.
    assign rdata = mem_q[ridx];
endmodule

// File: rtl/chain_rr_arbiter.sv
// chain_rr_arbiter: grants one hardware channel using a rotating order.
// It holds the grant for the whole descriptor chain and offers the
// channel with its descriptor pointer on a valid/ready bundle.
// Assumes chain_upd_i and chain_done_i come only from the engine that
// owns the current grant. Strobes sent while an offer is pending are dropped.
module chain_rr_arbiter #(
    parameter int NUM_CH = 256,
    parameter int PTR_W  = 32,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] req_i,
    input  logic              tbl_we_i,
    input  logic [CH_W-1:0]   tbl_idx_i,
    input  logic [PTR_W-1:0]  tbl_ptr_i,
    input  logic              chain_upd_i,
    input  logic [PTR_W-1:0]  chain_ptr_i,
    input  logic              chain_done_i,
    input  logic              out_ready_i,
    output logic              out_valid_o,
    output logic [CH_W-1:0]   out_ch_o,
    output logic [PTR_W-1:0]  out_ptr_o
);
    import arb_pkg::*;

    localparam logic [CH_W-1:0] LAST_INIT = CH_W'(NUM_CH - 1);

    arb_phase_e       phase_q;
    logic             valid_q;
    logic [CH_W-1:0]  ch_q;
    logic [CH_W-1:0]  last_q;
    logic [PTR_W-1:0] ptr_q;
    logic             hit;
    logic [CH_W-1:0]  win;
    logic [PTR_W-1:0] win_ptr;

    rr_pick #(.N(NUM_CH), .W(CH_W)) u_pick (
        .req   (req_i),
        .last  (last_q),
        .found (hit),
        .sel   (win)
    );

    ptr_table #(.N(NUM_CH), .W(CH_W), .PW(PTR_W)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we_i),
        .widx  (tbl_idx_i),
        .wdata (tbl_ptr_i),
        .ridx  (win),
        .rdata (win_ptr)
    );

    // Grant, offer handshake and chain sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            valid_q <= 1'b0;
            ch_q    <= '0;
            ptr_q   <= '0;
            last_q  <= LAST_INIT;
        end else if (phase_q == PH_IDLE) begin
            if (hit) begin
                phase_q <= PH_CHAIN;
                valid_q <= 1'b1;
                ch_q    <= win;
                ptr_q   <= win_ptr;
                last_q  <= win;
            end
        end else if (valid_q) begin
            if (out_ready_i) valid_q <= 1'b0;
        end else if (chain_done_i) begin
            phase_q <= PH_IDLE;
        end else if (chain_upd_i) begin
            ptr_q   <= chain_ptr_i;
            valid_q <= 1'b1;
        end
    end

    assign out_valid_o = valid_q;
    assign out_ch_o    = ch_q;
    assign out_ptr_o   = ptr_q;
endmodule

// File: rtl/chain_rr_arbiter_chk.sv
// chain_rr_arbiter_chk: temporal checks on the arbiter ports and phase.
// Bound into every chain_rr_arbiter instance.
module chain_rr_arbiter_chk #(
    parameter int NUM_CH = 256,
    parameter int PTR_W  = 32,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] req_i,
    input logic              chain_upd_i,
    input logic [PTR_W-1:0]  chain_ptr_i,
    input logic              chain_done_i,
    input logic              out_ready_i,
    input logic              out_valid_o,
    input logic [CH_W-1:0]   out_ch_o,
    input logic [PTR_W-1:0]  out_ptr_o,
    input logic              busy
);
    logic [NUM_CH-1:0] req_d;

    // Previous-cycle request vector for the grant check.
    always_ff @(posedge clk) begin
        if (!rst_n) req_d <= '0;
        else        req_d <= req_i;
    end

    a_r5_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_ch_o) && $stable(out_ptr_o));

    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && out_ready_i |=> !out_valid_o);

    a_r6_chain_update: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !out_valid_o && chain_upd_i && !chain_done_i
        |=> out_valid_o && $stable(out_ch_o) && out_ptr_o == $past(chain_ptr_i));

    a_r7_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(out_ch_o));

    a_r2_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && (|req_i) |=> out_valid_o && busy && req_d[out_ch_o]);

    a_r8_pending_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy && out_valid_o && chain_done_i |=> busy);

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !(|req_i) |=> !out_valid_o);
endmodule

bind chain_rr_arbiter chain_rr_arbiter_chk #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .chain_upd_i  (chain_upd_i),
    .chain_ptr_i  (chain_ptr_i),
    .chain_done_i (chain_done_i),
    .out_ready_i  (out_ready_i),
    .out_valid_o  (out_valid_o),
    .out_ch_o     (out_ch_o),
    .out_ptr_o    (out_ptr_o),
    .busy         (phase_q == arb_pkg::PH_CHAIN)
);

// File: tb/test_chain_rr_arbiter.sv
module test_chain_rr_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 256;
    localparam int CW  = 8;
    localparam int PW  = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] req = '0;
    logic           we = 1'b0;
    logic [CW-1:0]  widx = '0;
    logic [PW-1:0]  wptr = '0;
    logic           upd = 1'b0;
    logic [PW-1:0]  uptr = '0;
    logic           done = 1'b0;
    logic           ready = 1'b0;
    logic           valid;
    logic [CW-1:0]  ch;
    logic [PW-1:0]  ptr;

    int checks = 0;
    int failures = 0;

    chain_rr_arbiter #(.NUM_CH(NCH), .PTR_W(PW)) i_chain_rr_arbiter (
        .clk(clk), .rst_n(rst_n), .req_i(req), .tbl_we_i(we), .tbl_idx_i(widx),
        .tbl_ptr_i(wptr), .chain_upd_i(upd), .chain_ptr_i(uptr), .chain_done_i(done),
        .out_ready_i(ready), .out_valid_o(valid), .out_ch_o(ch), .out_ptr_o(ptr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model.
    bit          m_busy, m_valid;
    int          m_last, m_ch;
    logic [PW-1:0] m_ptr;
    logic [PW-1:0] m_tbl [NCH];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_valid = 0; m_last = NCH - 1; m_ch = 0; m_ptr = '0;
            for (int i = 0; i < NCH; i++) m_tbl[i] = '0;
        end else begin
            if (!m_busy) begin
                for (int k = 1; k <= NCH; k++) begin
                    if (!m_busy && req[(m_last + k) % NCH]) begin
                        m_ch = (m_last + k) % NCH;
                        m_last = m_ch; m_ptr = m_tbl[m_ch]; m_valid = 1; m_busy = 1;
                    end
                end
            end else if (m_valid) begin
                if (ready) m_valid = 0;
            end else if (done) begin
                m_busy = 0;
            end else if (upd) begin
                m_ptr = uptr; m_valid = 1;
            end
            if (we) m_tbl[widx] = wptr;
        end
    end

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (valid !== m_valid) begin
                failures++;
                $display("FAIL R7 valid: actual=%0b expected=%0b", valid, m_valid);
            end else if (m_valid && ch !== CW'(m_ch)) begin
                failures++;
                $display("FAIL R3 channel: actual=%0d expected=%0d", ch, m_ch);
            end else if (m_valid && ptr !== m_ptr) begin
                failures++;
                $display("FAIL R4 pointer: actual=%h expected=%h", ptr, m_ptr);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input int idx, input logic [PW-1:0] v);
        we = 1; widx = CW'(idx); wptr = v;
        step();
        we = 0;
    endtask

    // Accept the pending offer, then end the chain.
    task automatic finish_chain();
        ready = 1; step(); ready = 0;
        done = 1; step(); done = 0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) step();
        chk(valid == 1'b0, "R1 reset valid", int'(valid), 0);
        rst_n = 1;
        foreach (m_tbl[i]) ; // model initialised at reset
        wr(0, 32'hC0DE_0000); wr(3, 32'hC0DE_0003); wr(5, 32'hC0DE_0005);
        wr(6, 32'hC0DE_0006); wr(200, 32'hC0DE_00C8); wr(255, 32'hC0DE_00FF);
        // R9: idle without requests
        repeat (3) step();
        chk(valid == 1'b0, "R9 idle valid", int'(valid), 0);
        // R2: reset order, 5 and 6 together
        req[5] = 1; req[6] = 1;
        step();
        chk(valid && ch == 8'd5, "R2 first grant", int'(ch), 5);
        chk(ptr == 32'hC0DE_0005, "R4 table pointer", int'(ptr), 32'hC0DE_0005);
        // R5: hold while not ready
        repeat (3) step();
        chk(valid && ch == 8'd5 && ptr == 32'hC0DE_0005, "R5 hold", int'(ch), 5);
        ready = 1; step(); ready = 0;
        chk(valid == 1'b0, "R5 release", int'(valid), 0);
        // R7: requests still held during chain are ignored
        repeat (2) step();
        chk(valid == 1'b0, "R7 no regrant in chain", int'(valid), 0);
        // R6: chain update
        upd = 1; uptr = 32'h1111_0000; step(); upd = 0;
        chk(valid && ch == 8'd5 && ptr == 32'h1111_0000, "R6 update", int'(ptr), 32'h1111_0000);
        // R8: strobes while pending are dropped
        upd = 1; uptr = 32'h2222_0000; done = 1; step(); upd = 0; done = 0;
        chk(valid && ptr == 32'h1111_0000, "R8 pending update dropped", int'(ptr), 32'h1111_0000);
        ready = 1; step(); ready = 0;
        // R8: done wins over update
        upd = 1; uptr = 32'h3333_0000; done = 1; step(); upd = 0; done = 0;
        chk(valid == 1'b0, "R8 done over update", int'(valid), 0);
        // R3: next grant goes to 6
        step();
        chk(valid && ch == 8'd6, "R3 rotation to 6", int'(ch), 6);
        finish_chain();
        step();
        chk(valid && ch == 8'd5, "R3 back to 5", int'(ch), 5);
        req = '0;
        finish_chain();
        // R3: wrap past the top
        req[200] = 1; step(); req = '0;
        chk(valid && ch == 8'd200, "R3 grant 200", int'(ch), 200);
        finish_chain();
        req[3] = 1; req[255] = 1; step();
        chk(valid && ch == 8'd255, "R3 grant 255", int'(ch), 255);
        finish_chain();
        step();
        chk(valid && ch == 8'd3, "R3 wrap to 3", int'(ch), 3);
        req = '0;
        finish_chain();
        // R4: write in the grant cycle is not seen
        req[0] = 1; we = 1; widx = 0; wptr = 32'hBEEF_0000; step(); we = 0;
        chk(valid && ch == 8'd0 && ptr == 32'hC0DE_0000, "R4 old entry", int'(ptr), 32'hC0DE_0000);
        finish_chain();
        step();
        chk(valid && ch == 8'd0 && ptr == 32'hBEEF_0000, "R4 new entry lone requester", int'(ptr), 32'hBEEF_0000);
        req = '0;
        finish_chain();
        repeat (3) step();
        chk(valid == 1'b0, "R9 idle again", int'(valid), 0);
        summary();
    end
endmodule